// File: doc/BRIEF.md
# Segmented Write-Protect Filter for a 512-Byte Array

This block sits on the write path of a small byte-wide memory array. Each write request carries an address and a data byte. The block forwards the request to the array one clock later, unless the address lies inside the region that a 3-bit protection setting currently guards. In that case the write is dropped silently, and a one-cycle pulse reports the rejection instead. Read requests always reach the array, and the protection setting never affects them.

The protection setting is held in an internal register. Software changes it through a separate configuration write port, and the register value is visible at an output. The eight settings split into two families:

- **Upper-region settings** guard the top quarter, the top half or the whole array.
- **Low-page settings** guard the first 4, 8 or 16 pages of 16 bytes, or the whole array.

A write burst is a run of write beats that ends with a beat marked last. A small state machine keeps the protection setting fixed for the whole burst:

- **ST_IDLE to ST_BURST** ("open"): a write beat without the last mark, seen in ST_IDLE, moves the machine to ST_BURST and snapshots the live setting.
- **ST_BURST to ST_IDLE** ("close"): a write beat with the last mark, seen in ST_BURST, returns the machine to ST_IDLE.
- **Hold**: every other cycle leaves the state unchanged, and that includes reads and idle cycles.

In ST_IDLE, a write uses the live register value. In ST_BURST, every beat uses the snapshot. Each beat is still checked against its own address, so in a burst only the guarded bytes are dropped.

Top module: `bp_write_filter`

## Requirements
- R1: While reset is asserted and after it is released, `prot_code` reads 000 and `mem_we`, `mem_re` and `wr_reject` are low until a request arrives.
- R2: With setting 000, every write beat appears one cycle later as `mem_we`=1 with the same address on `mem_addr` and the same byte on `mem_wdata`.
- R3: Setting 001 rejects writes to 0x180–0x1FF and forwards writes to 0x000–0x17F.
- R4: Setting 010 rejects writes to 0x100–0x1FF and forwards writes to 0x000–0x0FF.
- R5: Settings 011 and 111 reject writes to every address from 0x000 to 0x1FF.
- R6: Settings 100, 101 and 110 reject writes below 0x040, 0x080 and 0x100 respectively, and forward writes at or above those addresses.
- R7: Each write beat produces, one cycle later, exactly one of these outcomes: `mem_we` for one cycle, or `wr_reject` for one cycle. Cycles without a write beat produce neither.
- R8: A read request (`req_valid`=1, `req_write`=0) produces `mem_re`=1 one cycle later with the request address on `mem_addr`, whatever the setting is.
- R9: Within a burst, each beat is accepted or rejected according to its own address. A burst that crosses a region boundary therefore loses only its guarded bytes.
- R10: A setting change applies from the next write request onward:
  - A change made during a burst does not apply to the rest of that burst.
  - A change issued in the same cycle as an idle write does not apply to that write.
- R11: A configuration write (`cfg_we`=1) makes `prot_code` equal to `cfg_code` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write beat, 0 = read |
| req_last | input | 1 | Write beat closes its burst (a lone write sets it) |
| req_addr | input | 9 | Byte address |
| req_wdata | input | 8 | Write data byte |
| cfg_we | input | 1 | Load a new protection setting |
| cfg_code | input | 3 | Protection setting to load |
| prot_code | output | 3 | Current protection setting |
| mem_we | output | 1 | Forwarded write strobe to the array |
| mem_re | output | 1 | Forwarded read strobe to the array |
| mem_addr | output | 9 | Address for the array |
| mem_wdata | output | 8 | Write data for the array |
| wr_reject | output | 1 | One-cycle pulse for a dropped write |

## Verification
A stuck or wrong burst state is seen at the ports as beats judged against the wrong setting. The symptom is a `wr_reject` where `mem_we` was due, or the reverse. It shows on the cycle after the first beat that follows a setting change, so the tests change the setting in the middle of a burst and in the same cycle as an idle write. A wrong snapshot or a wrong decode boundary shows one cycle after a write to an address next to a region edge, so every edge is probed from both sides. A lost or corrupted register load shows at `prot_code` one cycle after the load.

// File: rtl/bp_filter_pkg.sv
package bp_filter_pkg;

    // Burst tracking states
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    // Protection settings; the encoding is decoded by bp_range_decode
    localparam logic [2:0] PC_OPEN   = 3'b000;
    localparam logic [2:0] PC_UPQ    = 3'b001;
    localparam logic [2:0] PC_UPH    = 3'b010;
    localparam logic [2:0] PC_ALL_A  = 3'b011;
    localparam logic [2:0] PC_PG_S   = 3'b100;
    localparam logic [2:0] PC_PG_M   = 3'b101;
    localparam logic [2:0] PC_PG_L   = 3'b110;
    localparam logic [2:0] PC_ALL_B  = 3'b111;

    localparam int unsigned CODE_W = 3;

endpackage

// File: rtl/bp_code_reg.sv
module bp_code_reg
    import bp_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_val,
    output logic [CODE_W-1:0] code_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= PC_OPEN;
        end else if (load) begin
            code_q <= load_val;
        end
    end

endmodule

// File: rtl/bp_burst_fsm.sv
module bp_burst_fsm
    import bp_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_beat,
    input  logic              wr_last,
    input  logic [CODE_W-1:0] live_code,
    output logic [CODE_W-1:0] eff_code,
    output logic              in_burst
);

    burst_state_e      state_q, state_d;
    logic [CODE_W-1:0] snap_q;

    // State register and the setting snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            snap_q  <= PC_OPEN;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && wr_beat) begin
                snap_q <= live_code;
            end
        end
    end

    // Transitions: open (idle, non-last beat), close (burst, last beat)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_beat && !wr_last) begin
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                if (wr_beat && wr_last) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Setting that governs the present beat
    always_comb begin
        eff_code = live_code;
        in_burst = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                eff_code = live_code;
                in_burst = 1'b0;
            end
            ST_BURST: begin
                eff_code = snap_q;
                in_burst = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bp_range_decode.sv
module bp_range_decode
    import bp_filter_pkg::*;
#(
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned PAGE_BYTES = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic [ADDR_W-1:0] addr,
    output logic              guarded
);

    localparam int unsigned SPAN    = 1 << ADDR_W;
    localparam int unsigned N_PAGES = 3;
    localparam logic [ADDR_W:0] UPQ_BASE = (ADDR_W+1)'((SPAN / 4) * 3);
    localparam logic [ADDR_W:0] UPH_BASE = (ADDR_W+1)'(SPAN / 2);

    logic [ADDR_W:0]      addr_x;
    logic [N_PAGES-1:0]   low_hit;

    assign addr_x = {1'b0, addr};

    // Low-page limits: 4, 8 and 16 pages
    for (genvar k = 0; k < N_PAGES; k++) begin : g_page_lim
        localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(PAGE_BYTES << (k + 2));
        assign low_hit[k] = (addr_x < LIM);
    end

    always_comb begin
        guarded = 1'b0;
        unique case (code)
            PC_OPEN:  guarded = 1'b0;
            PC_UPQ:   guarded = (addr_x >= UPQ_BASE);
            PC_UPH:   guarded = (addr_x >= UPH_BASE);
            PC_ALL_A: guarded = 1'b1;
            PC_PG_S:  guarded = low_hit[0];
            PC_PG_M:  guarded = low_hit[1];
            PC_PG_L:  guarded = low_hit[2];
            PC_ALL_B: guarded = 1'b1;
        endcase
    end

endmodule

// File: rtl/bp_write_filter.sv
module bp_write_filter
    import bp_filter_pkg::*;
#(
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_last,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_code,
    output logic [2:0]        prot_code,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wr_reject
);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] eff_code;
    logic              in_burst;
    logic              guarded;
    logic              wr_beat;
    logic              rd_beat;

    assign wr_beat   = req_valid && req_write;
    assign rd_beat   = req_valid && !req_write;
    assign prot_code = code_q;

    bp_code_reg u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_we),
        .load_val (cfg_code),
        .code_q   (code_q)
    );

    bp_burst_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_beat   (wr_beat),
        .wr_last   (req_last),
        .live_code (code_q),
        .eff_code  (eff_code),
        .in_burst  (in_burst)
    );

    bp_range_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_dec (
        .code    (eff_code),
        .addr    (req_addr),
        .guarded (guarded)
    );

    // Output stage: one register on every path to the array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            wr_reject <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= wr_beat && !guarded;
            mem_re    <= rd_beat;
            wr_reject <= wr_beat && guarded;
            if (req_valid) begin
                mem_addr <= req_addr;
            end
            if (wr_beat && !guarded) begin
                mem_wdata <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/bp_write_filter_chk.sv
module bp_write_filter_chk #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cfg_we,
    input logic [2:0]        cfg_code,
    input logic [2:0]        prot_code,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wr_reject
);

    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && wr_reject));

    assert_write_resolved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (mem_we || wr_reject));

    assert_no_stray_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> !(mem_we || wr_reject));

    assert_read_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (mem_re && mem_addr == $past(req_addr)));

    assert_code_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (prot_code == $past(cfg_code)));

    assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(prot_code));

endmodule

bind bp_write_filter bp_write_filter_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .cfg_we    (cfg_we),
    .cfg_code  (cfg_code),
    .prot_code (prot_code),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .wr_reject (wr_reject)
);

// File: tb/bp_write_filter_tb.sv
`timescale 1ns/1ps
module bp_write_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_last = 1'b0;
    logic [8:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_code = '0;
    logic [2:0] prot_code;
    logic       mem_we, mem_re, wr_reject;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    string tag   = "R1";
    int rej_seen = 0;
    int rej_exp  = 0;

    always #2 clk = ~clk;   // 250 MHz

    bp_write_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_last(req_last),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_we(cfg_we), .cfg_code(cfg_code), .prot_code(prot_code),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wr_reject(wr_reject)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model of the protection map
    function automatic bit m_guard(input int code, input int a);
        case (code)
            0: return 1'b0;
            1: return a >= 384;
            2: return a >= 256;
            3: return 1'b1;
            4: return a < 64;
            5: return a < 128;
            6: return a < 256;
            default: return 1'b1;
        endcase
    endfunction

    int m_code = 0, m_snap = 0;
    bit m_burst = 0;
    bit e_we, e_re, e_rej;
    int e_addr, e_data;

    // Reference model, compared on every clock just after the edge
    always @(posedge clk) begin
        bit wb, rb, g;
        int use_code;
        if (!rst_n) begin
            m_code = 0; m_snap = 0; m_burst = 0;
            e_we = 0; e_re = 0; e_rej = 0;
        end else begin
            wb = req_valid && req_write;
            rb = req_valid && !req_write;
            use_code = m_burst ? m_snap : m_code;
            g = m_guard(use_code, int'(req_addr));
            e_we  = wb && !g;
            e_rej = wb && g;
            e_re  = rb;
            e_addr = int'(req_addr);
            e_data = int'(req_wdata);
            if (wb && !m_burst && !req_last) begin
                m_burst = 1; m_snap = m_code;
            end else if (wb && m_burst && req_last) begin
                m_burst = 0;
            end
            if (cfg_we) m_code = int'(cfg_code);
            if (e_rej) rej_exp++;
        end
        #1;
        if (wr_reject) rej_seen++;
        check(mem_we == e_we, tag, mem_we, e_we, "mem_we");
        check(wr_reject == e_rej, tag, wr_reject, e_rej, "wr_reject");
        check(mem_re == e_re, (tag == "R1") ? "R1" : "R8", mem_re, e_re, "mem_re");
        check(int'(prot_code) == m_code, "R11", prot_code, m_code, "prot_code");
        if (e_we) begin
            check(int'(mem_addr) == e_addr, tag, mem_addr, e_addr, "mem_addr");
            check(int'(mem_wdata) == e_data, tag, mem_wdata, e_data, "mem_wdata");
        end
        if (e_re) check(int'(mem_addr) == e_addr, "R8", mem_addr, e_addr, "read addr");
    end

    task automatic beat(input bit v, input bit w, input bit last, input int a, input int d,
                        input bit cw, input int cc);
        @(negedge clk);
        req_valid = v; req_write = w; req_last = last;
        req_addr = 9'(a); req_wdata = 8'(d);
        cfg_we = cw; cfg_code = 3'(cc);
        @(negedge clk);
        req_valid = 0; req_write = 0; req_last = 0; cfg_we = 0;
    endtask

    task automatic wr1(input int a, input int d);
        beat(1, 1, 1, a, d, 0, 0);
    endtask

    task automatic set_code(input int c);
        beat(0, 0, 0, 0, 0, 1, c);
    endtask

    // Burst beat with no idle cycle after it
    task automatic bbeat(input int a, input int d, input bit last);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_last = last;
        req_addr = 9'(a); req_wdata = 8'(d); cfg_we = 0;
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check(prot_code == 3'd0 && !mem_we && !mem_re && !wr_reject, "R1",
              {prot_code, mem_we, mem_re, wr_reject}, 0, "reset state");
        rst_n = 1;
        repeat (2) @(negedge clk);

        tag = "R2";
        wr1(9'h000, 8'hA5); wr1(9'h0FF, 8'h3C); wr1(9'h1FF, 8'hC3);

        tag = "R3"; set_code(1);
        wr1(9'h17F, 8'h11); wr1(9'h180, 8'h12); wr1(9'h1FF, 8'h13);
        tag = "R4"; set_code(2);
        wr1(9'h0FF, 8'h21); wr1(9'h100, 8'h22);
        tag = "R5"; set_code(3);
        wr1(9'h000, 8'h31); wr1(9'h1FF, 8'h32);
        tag = "R8";
        beat(1, 0, 0, 9'h055, 0, 0, 0); beat(1, 0, 0, 9'h1AA, 0, 0, 0);
        tag = "R5"; set_code(7);
        wr1(9'h000, 8'h71); wr1(9'h123, 8'h72);
        tag = "R6"; set_code(4);
        wr1(9'h03F, 8'h41); wr1(9'h040, 8'h42);
        set_code(5);
        wr1(9'h07F, 8'h51); wr1(9'h080, 8'h52);
        set_code(6);
        wr1(9'h0FF, 8'h61); wr1(9'h100, 8'h62);

        tag = "R9"; set_code(1);
        for (int i = 0; i < 8; i++) bbeat(9'h17C + i, 8'h80 + i, i == 7);
        @(negedge clk); req_valid = 0; req_write = 0; req_last = 0;

        tag = "R10"; set_code(0);
        bbeat(9'h100, 8'hE0, 0);
        @(negedge clk); req_valid = 0; cfg_we = 1; cfg_code = 3'd7;
        bbeat(9'h101, 8'hE1, 0);
        bbeat(9'h102, 8'hE2, 1);
        @(negedge clk); req_valid = 0; req_write = 0; req_last = 0;
        wr1(9'h103, 8'hE3);
        beat(1, 1, 1, 9'h010, 8'hE4, 1, 0);
        wr1(9'h011, 8'hE5);

        repeat (3) @(negedge clk);
        check(rej_seen == rej_exp, "R7", rej_seen, rej_exp, "reject pulse count");
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (200000) @(posedge clk);
                check(0, "WATCHDOG", 0, 1, "timeout");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule